// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block sits on the device side of an asynchronous DRAM strobe interface. It samples the active-low row strobe, four column strobes, write enable and output enable on a system clock. From the order in which those strobes change, it decides what kind of cycle each row-strobe-low period was. The kinds are a plain read, an early write, a read-then-write on the same column, a refresh of the row given on the address bus, a refresh that uses the internal row counter, and a refresh slipped in while a column strobe is still held from the access before. When the row strobe rises, it reports a 3-bit cycle code for one clock.

Every cycle that refreshes a row also reports which row it was. Accesses and address-driven refreshes use the row latched when the row strobe fell. Counter refreshes use the internal counter, which then steps by one and wraps at the row count. The counter value is visible at all times, so a bench can confirm that every row is visited. A drive flag models when the data pins would be driven under extended-data-out rules. The block is meant to run next to a memory controller as a protocol partner or checker. Strobe orderings it does not recognise are flagged as protocol errors.

Top module: `dram_cycle_sorter`

## Requirements
- R1: After synchronous reset, cyc_valid, proto_err, rfr_valid and dq_oe are 0 and rfr_ctr is 0.
- R2: Row strobe falls with all column strobes high, then a column strobe falls with we_n high: the cycle is reported with code 1 (read) and refreshes the row address latched when the row strobe fell.
- R3: we_n low when the first column strobe falls makes code 2 (early write); dq_oe stays 0 for the whole cycle.
- R4: In a read cycle, we_n going low while a column strobe is low makes code 3 (read-write); dq_oe returns to 0 in the cycle after we_n is sampled low.
- R5: A row-strobe-low period with no column strobe ever low is code 4; it refreshes the latched row and dq_oe stays 0.
- R6: Any column strobe low when the row strobe falls, with no access holding the strobe, gives code 5; it refreshes the row held in rfr_ctr, the counter then steps by one, and dq_oe stays 0.
- R7: If a column strobe was held low continuously since an access cycle ended and the row strobe falls again, the cycle is code 6. It refreshes from and advances the counter, and dq_oe keeps its previous value.
- R8: rfr_ctr wraps from 2^ROW_BITS-1 to 0, and changes only by one step, at the report of a code 5 or code 6 cycle.
- R9: dq_oe rises in the cycle after a read's column strobe and oe_n low are sampled. It stays 1 after the column strobes rise while the row strobe is low. It drops once oe_n is sampled high, or once the row strobe and all column strobes are sampled high.
- R10: A new column strobe falling edge during a code 5 or code 6 cycle makes the report code 7 with proto_err high. That cycle refreshes nothing and leaves the counter unchanged.
- R11: cyc_valid is a single-cycle pulse, high in the cycle after the clock edge at which ras_n is first sampled high following a low period; cyc_code is 0 whenever cyc_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | CAS_N | Column strobes, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_BITS | Multiplexed row/column address |
| cyc_valid | output | 1 | One-cycle pulse with each cycle report |
| cyc_code | output | 3 | Cycle kind: 1 read, 2 early write, 3 read-write, 4 address refresh, 5 counter refresh, 6 hidden refresh, 7 error |
| proto_err | output | 1 | Pulse with a code 7 report |
| rfr_valid | output | 1 | Pulse when a row was refreshed |
| rfr_row | output | ROW_BITS | Row refreshed with rfr_valid |
| rfr_ctr | output | ROW_BITS | Row the next counter refresh will use |
| dq_oe | output | 1 | Data pins would be driven |

## Verification
The hardest situation to reach is the hidden refresh. It needs a read whose column strobe stays low across the rising and the next falling row strobe, with the drive flag carried through both edges, so the bench builds it as one directed sequence. The counter wrap needs thousands of counter refreshes, so a short loop of compact refresh cycles steps the counter to its last row before the checked wrap. The error case uses a counter refresh in which the column strobes rise and one falls again under a low row strobe.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [2:0] {
        CY_NONE    = 3'd0,
        CY_READ    = 3'd1,
        CY_EWRITE  = 3'd2,
        CY_RDWR    = 3'd3,
        CY_RASONLY = 3'd4,
        CY_CBR     = 3'd5,
        CY_HIDDEN  = 3'd6,
        CY_ERR     = 3'd7
    } cyc_code_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT,
        PH_RD,
        PH_WR,
        PH_RW,
        PH_CBR,
        PH_HID,
        PH_BAD
    } phase_e;

    typedef struct packed {
        logic      valid;
        cyc_code_e code;
    } report_t;

    function automatic cyc_code_e phase_to_code(input phase_e p);
        case (p)
            PH_WAIT: return CY_RASONLY;
            PH_RD:   return CY_READ;
            PH_WR:   return CY_EWRITE;
            PH_RW:   return CY_RDWR;
            PH_CBR:  return CY_CBR;
            PH_HID:  return CY_HIDDEN;
            PH_BAD:  return CY_ERR;
            default: return CY_NONE;
        endcase
    endfunction

    function automatic logic uses_counter(input cyc_code_e c);
        return (c == CY_CBR) || (c == CY_HIDDEN);
    endfunction

endpackage

// File: rtl/dcs_seq.sv
module dcs_seq
    import dcs_pkg::*;
#(
    parameter int CAS_N    = 4,
    parameter int ROW_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ras_n,
    input  logic [CAS_N-1:0]    cas_n,
    input  logic                we_n,
    input  logic [ROW_BITS-1:0] addr,
    output logic                commit,
    output cyc_code_e           commit_code,
    output logic [ROW_BITS-1:0] row_q,
    output logic                rd_set,
    output report_t             rep,
    output logic                proto_err
);

    logic             ras_prev;
    logic [CAS_N-1:0] cas_prev;
    phase_e           ph_q, ph_d;
    logic             hold_q;
    logic             any_low, ras_fall, ras_rise, cas_fall;

    assign any_low  = ~&cas_n;
    assign ras_fall = ras_prev & ~ras_n;
    assign ras_rise = ~ras_prev & ras_n;
    assign cas_fall = |(cas_prev & ~cas_n);

    always_comb begin
        ph_d = ph_q;
        if (ras_fall) begin
            if (any_low) ph_d = hold_q ? PH_HID : PH_CBR;
            else         ph_d = PH_WAIT;
        end else if (ras_rise) begin
            ph_d = PH_IDLE;
        end else begin
            case (ph_q)
                PH_WAIT: if (any_low) ph_d = we_n ? PH_RD : PH_WR;
                PH_RD:   if (any_low && !we_n) ph_d = PH_RW;
                PH_CBR,
                PH_HID:  if (cas_fall) ph_d = PH_BAD;
                default: ph_d = ph_q;
            endcase
        end
    end

    assign commit      = ras_rise;
    assign commit_code = phase_to_code(ph_q);
    assign rd_set      = (ph_d == PH_RD) && any_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_prev  <= 1'b1;
            cas_prev  <= '1;
            ph_q      <= PH_IDLE;
            hold_q    <= 1'b0;
            row_q     <= '0;
            rep       <= '{valid: 1'b0, code: CY_NONE};
            proto_err <= 1'b0;
        end else begin
            ras_prev  <= ras_n;
            cas_prev  <= cas_n;
            ph_q      <= ph_d;
            if (ras_fall) row_q <= addr;
            if (!any_low)
                hold_q <= 1'b0;
            else if (ras_rise && (ph_q == PH_RD || ph_q == PH_WR ||
                                  ph_q == PH_RW || ph_q == PH_HID))
                hold_q <= 1'b1;
            rep.valid <= ras_rise;
            rep.code  <= ras_rise ? commit_code : CY_NONE;
            proto_err <= ras_rise && (ph_q == PH_BAD);
        end
    end

endmodule

// File: rtl/dcs_rowctr.sv
module dcs_rowctr
    import dcs_pkg::*;
#(
    parameter int ROW_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  cyc_code_e           commit_code,
    input  logic [ROW_BITS-1:0] row_q,
    output logic                rfr_valid,
    output logic [ROW_BITS-1:0] rfr_row,
    output logic [ROW_BITS-1:0] ctr
);

    logic from_ctr;
    assign from_ctr = uses_counter(commit_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            rfr_valid <= 1'b0;
            rfr_row   <= '0;
            ctr       <= '0;
        end else begin
            rfr_valid <= commit && (commit_code != CY_ERR) && (commit_code != CY_NONE);
            if (commit) rfr_row <= from_ctr ? ctr : row_q;
            if (commit && from_ctr) ctr <= ctr + 1'b1;
        end
    end

endmodule

// File: rtl/dcs_dqen.sv
module dcs_dqen #(
    parameter int CAS_N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_n,
    input  logic [CAS_N-1:0] cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic             rd_set,
    output logic             dq_oe
);

    logic all_up;
    assign all_up = ras_n && (&cas_n);

    always_ff @(posedge clk) begin
        if (rst)               dq_oe <= 1'b0;
        else if (oe_n)         dq_oe <= 1'b0;
        else if (all_up)       dq_oe <= 1'b0;
        else if (!we_n)        dq_oe <= 1'b0;
        else if (rd_set)       dq_oe <= 1'b1;
    end

endmodule

// File: rtl/dram_cycle_sorter.sv
module dram_cycle_sorter
    import dcs_pkg::*;
#(
    parameter int ROW_BITS = 12,
    parameter int CAS_N    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ras_n,
    input  logic [CAS_N-1:0]    cas_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [ROW_BITS-1:0] addr,
    output logic                cyc_valid,
    output logic [2:0]          cyc_code,
    output logic                proto_err,
    output logic                rfr_valid,
    output logic [ROW_BITS-1:0] rfr_row,
    output logic [ROW_BITS-1:0] rfr_ctr,
    output logic                dq_oe
);

    logic                commit;
    cyc_code_e           commit_code;
    logic [ROW_BITS-1:0] row_q;
    logic                rd_set;
    report_t             rep;

    dcs_seq #(.CAS_N(CAS_N), .ROW_BITS(ROW_BITS)) u_seq (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .commit(commit), .commit_code(commit_code),
        .row_q(row_q), .rd_set(rd_set), .rep(rep), .proto_err(proto_err)
    );

    dcs_rowctr #(.ROW_BITS(ROW_BITS)) u_ctr (
        .clk(clk), .rst(rst), .commit(commit), .commit_code(commit_code),
        .row_q(row_q), .rfr_valid(rfr_valid), .rfr_row(rfr_row), .ctr(rfr_ctr)
    );

    dcs_dqen #(.CAS_N(CAS_N)) u_dq (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .rd_set(rd_set), .dq_oe(dq_oe)
    );

    assign cyc_valid = rep.valid;
    assign cyc_code  = rep.code;

endmodule

// File: rtl/dcs_chk.sv
module dcs_chk #(
    parameter int ROW_BITS = 12,
    parameter int CAS_N    = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                ras_n,
    input logic [CAS_N-1:0]    cas_n,
    input logic                oe_n,
    input logic                cyc_valid,
    input logic [2:0]          cyc_code,
    input logic                proto_err,
    input logic                rfr_valid,
    input logic [ROW_BITS-1:0] rfr_ctr,
    input logic                dq_oe
);

    AST_REPORT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |-> ($past(ras_n) && !$past(ras_n, 2)));               // R11
    AST_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |-> (cyc_code == 3'd0));                               // R11
    AST_ERR_NO_REFRESH: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> !rfr_valid);                                        // R10
    AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(rfr_ctr) |-> (rfr_ctr == $past(rfr_ctr) + 1'b1));         // R8
    AST_CTR_ON_REFRESH: assert property (@(posedge clk) disable iff (rst)
        !$stable(rfr_ctr) |-> (cyc_valid && (cyc_code == 3'd5 || cyc_code == 3'd6))); // R8
    AST_OE_HIGH_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(oe_n) |-> !dq_oe);                                          // R9
    AST_ALL_UP_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(ras_n && (&cas_n)) |-> !dq_oe);                             // R9

endmodule

bind dram_cycle_sorter dcs_chk #(.ROW_BITS(ROW_BITS), .CAS_N(CAS_N)) u_chk (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
    .cyc_valid(cyc_valid), .cyc_code(cyc_code), .proto_err(proto_err),
    .rfr_valid(rfr_valid), .rfr_ctr(rfr_ctr), .dq_oe(dq_oe)
);

// File: tb/sim_dram_cycle_sorter.sv
`timescale 1ns/1ps
module sim_dram_cycle_sorter;

    localparam int RB = 12;
    localparam int NV = 8;
    // {kind[2:0], row[11:0], expected code[2:0]}; kind 0 rd, 1 ewr, 2 rdwr, 3 ras-only, 4 counter refresh
    localparam logic [17:0] VEC [NV] = '{
        {3'd0, 12'h123, 3'd1},
        {3'd1, 12'hABC, 3'd2},
        {3'd2, 12'h7FF, 3'd3},
        {3'd3, 12'h055, 3'd4},
        {3'd4, 12'hFFF, 3'd5},
        {3'd0, 12'hF00, 3'd1},
        {3'd3, 12'h800, 3'd4},
        {3'd4, 12'h001, 3'd5}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ras_n = 1'b1;
    logic [3:0]    cas_n = 4'hF;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [RB-1:0] addr = '0;
    logic          cyc_valid, proto_err, rfr_valid, dq_oe;
    logic [2:0]    cyc_code;
    logic [RB-1:0] rfr_row, rfr_ctr;

    int checks = 0;
    int fails  = 0;
    int ctr_m  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dram_cycle_sorter u0 (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .cyc_valid(cyc_valid), .cyc_code(cyc_code),
        .proto_err(proto_err), .rfr_valid(rfr_valid), .rfr_row(rfr_row),
        .rfr_ctr(rfr_ctr), .dq_oe(dq_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // raise RAS, check the report, then release CAS
    task automatic finish_cycle(input int code, input int row, input bit refr, input string req);
        ras_n = 1'b1;
        tick(1);
        chk(cyc_valid == 1'b1, {req, " valid"}, cyc_valid, 1);
        chk(cyc_code == code[2:0], {req, " code"}, cyc_code, code);
        chk(rfr_valid == refr, {req, " refresh"}, rfr_valid, refr);
        if (refr) chk(rfr_row == row[RB-1:0], {req, " row"}, rfr_row, row);
        chk(rfr_ctr == ctr_m[RB-1:0], "R8 counter", rfr_ctr, ctr_m);
        cas_n = 4'hF; we_n = 1'b1; oe_n = 1'b1;
        tick(1);
        chk(cyc_valid == 1'b0, "R11 pulse width", cyc_valid, 0);
        chk(cyc_code == 3'd0, "R11 idle code", cyc_code, 0);
    endtask

    task automatic run_kind(input int kind, input int row, input int code);
        int exp_row;
        exp_row = row;
        case (kind)
            0, 2: begin
                addr = row[RB-1:0]; ras_n = 1'b0; tick(1);
                addr = ~row[RB-1:0]; oe_n = 1'b0; cas_n = 4'h0; tick(1);
                chk(dq_oe == 1'b1, "R9 drive on", dq_oe, 1);
                if (kind == 2) begin
                    we_n = 1'b0; tick(1);
                    chk(dq_oe == 1'b0, "R4 drive off at write", dq_oe, 0);
                end else begin
                    cas_n = 4'hF; tick(1);
                    chk(dq_oe == 1'b1, "R9 edo hold", dq_oe, 1);
                end
            end
            1: begin
                addr = row[RB-1:0]; ras_n = 1'b0; tick(1);
                we_n = 1'b0; oe_n = 1'b0; tick(1);
                cas_n = 4'h0; tick(2);
                chk(dq_oe == 1'b0, "R3 no drive", dq_oe, 0);
            end
            3: begin
                addr = row[RB-1:0]; oe_n = 1'b0; ras_n = 1'b0; tick(3);
                chk(dq_oe == 1'b0, "R5 no drive", dq_oe, 0);
            end
            default: begin
                cas_n = 4'h0; tick(1);
                addr = row[RB-1:0]; oe_n = 1'b0; ras_n = 1'b0; tick(3);
                chk(dq_oe == 1'b0, "R6 no drive", dq_oe, 0);
                exp_row = ctr_m;
                ctr_m = (ctr_m + 1) % (1 << RB);
            end
        endcase
        case (kind)
            0: finish_cycle(code, exp_row, 1'b1, "R2 read");
            1: finish_cycle(code, exp_row, 1'b1, "R3 early write");
            2: finish_cycle(code, exp_row, 1'b1, "R4 read-write");
            3: finish_cycle(code, exp_row, 1'b1, "R5 ras-only");
            default: finish_cycle(code, exp_row, 1'b1, "R6 counter refresh");
        endcase
    endtask

    task automatic quick_cbr();
        cas_n = 4'h0; tick(1);
        ras_n = 1'b0; tick(1);
        ras_n = 1'b1; tick(1);
        cas_n = 4'hF; tick(1);
        ctr_m = (ctr_m + 1) % (1 << RB);
    endtask

    task automatic do_reset();
        rst = 1'b1; ras_n = 1'b1; cas_n = 4'hF; we_n = 1'b1; oe_n = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(1);
        ctr_m = 0;
        chk(cyc_valid == 1'b0, "R1 valid", cyc_valid, 0);
        chk(proto_err == 1'b0, "R1 proto_err", proto_err, 0);
        chk(rfr_valid == 1'b0, "R1 rfr_valid", rfr_valid, 0);
        chk(dq_oe == 1'b0, "R1 dq_oe", dq_oe, 0);
        chk(rfr_ctr == '0, "R1 counter", rfr_ctr, 0);
    endtask

    initial begin
        do_reset();

        for (int i = 0; i < NV; i++)
            run_kind(int'(VEC[i][17:15]), int'(VEC[i][14:3]), int'(VEC[i][2:0]));

        // R7 hidden refresh after a read with CAS held low
        addr = 12'h3C3; ras_n = 1'b0; tick(1);
        oe_n = 1'b0; cas_n = 4'h0; tick(1);
        chk(dq_oe == 1'b1, "R9 drive on", dq_oe, 1);
        ras_n = 1'b1; tick(1);
        chk(cyc_code == 3'd1, "R2 read before hidden", cyc_code, 1);
        chk(dq_oe == 1'b1, "R7 drive kept at rise", dq_oe, 1);
        ras_n = 1'b0; tick(2);
        chk(dq_oe == 1'b1, "R7 drive kept in hidden", dq_oe, 1);
        ras_n = 1'b1; tick(1);
        chk(cyc_code == 3'd6, "R7 hidden code", cyc_code, 6);
        chk(rfr_valid && rfr_row == ctr_m[RB-1:0], "R7 hidden row", rfr_row, ctr_m);
        ctr_m = (ctr_m + 1) % (1 << RB);
        tick(1);
        chk(rfr_ctr == ctr_m[RB-1:0], "R7 counter step", rfr_ctr, ctr_m);
        cas_n = 4'hF; tick(1);
        chk(dq_oe == 1'b0, "R9 off after last rise", dq_oe, 0);
        oe_n = 1'b1;

        // R9 OE high turns drive off during RAS low
        addr = 12'h010; ras_n = 1'b0; tick(1);
        oe_n = 1'b0; cas_n = 4'h0; tick(1);
        oe_n = 1'b1; tick(1);
        chk(dq_oe == 1'b0, "R9 oe high off", dq_oe, 0);
        finish_cycle(1, 12'h010, 1'b1, "R2 read");

        // R10 column strobe refalls inside a counter refresh
        cas_n = 4'h0; tick(1);
        ras_n = 1'b0; tick(1);
        cas_n = 4'hF; tick(1);
        cas_n = 4'hD; tick(1);
        ras_n = 1'b1; tick(1);
        chk(cyc_code == 3'd7, "R10 error code", cyc_code, 7);
        chk(proto_err == 1'b1, "R10 proto_err", proto_err, 1);
        chk(rfr_valid == 1'b0, "R10 no refresh", rfr_valid, 0);
        chk(rfr_ctr == ctr_m[RB-1:0], "R10 counter kept", rfr_ctr, ctr_m);
        cas_n = 4'hF; tick(2);

        // R8 wrap
        while (ctr_m != (1 << RB) - 1) quick_cbr();
        chk(rfr_ctr == 12'hFFF, "R8 at last row", rfr_ctr, 4095);
        run_kind(4, 0, 5);
        chk(rfr_ctr == '0, "R8 wrapped", rfr_ctr, 0);

        // R1 reset clears the counter
        quick_cbr();
        do_reset();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule